// File: doc/BRIEF.md
# Per-Range ADC Calibration Loader and Corrector

This block keeps a signed offset and an unsigned gain for each of four ADC sample lanes and corrects every incoming 16-bit sample with them. The coefficients depend on the analogue input range. Each range has a small record in a byte-wide calibration store, which the block reads through a one-outstanding request/response port.

After reset, and whenever the range selector moves to a new legal code, the block reads the offset and gain words of that range one byte at a time. It stages them while it reads and then switches all eight coefficients in a single cycle. Samples keep flowing the whole time. They use the previous coefficient set until the switch. A range change that arrives in the middle of a load is held and served once the current load ends.

The correction is a two-stage pipeline: add the offset, then scale by the gain in Q1.15 and saturate.

Top module: `adc_cal_corrector`

## Requirements
- R1: During and right after reset, `busy`, `rd_req` and `m_valid` are low. Until the first load commits, every lane uses offset 0 and gain 0x8000, which is unity, so samples pass through unchanged.
- R2: After reset is released, and on every change of `range_sel` to a legal code (0 selects 10 V, 1 selects 1 V, 2 selects 100 mV), the block issues exactly 16 byte reads in ascending order. The addresses are `18*code + 0` through `18*code + 15`. The two temperature bytes at `18*code + 16` and `18*code + 17` are never read.
- R3: Words are little-endian. The byte at the even address forms bits 7:0 of a word, and the following odd address forms bits 15:8.
- R4: Record words 0 to 3 are the signed offsets of lanes 0 to 3. Words 4 to 7 are the unsigned gains of lanes 0 to 3. Lane n occupies bits 16n+15 down to 16n of `s_data` and `m_data`.
- R5: `busy` is high from the cycle after a load starts until the edge that commits it. All eight coefficients change together on that edge. A sample presented before that edge is corrected with the old set.
- R6: Code 3 on `range_sel` is ignored. Reselecting the range that is already loaded also starts no reads.
- R7: A legal range change that arrives during a load is latched. Its load begins one cycle after the current load commits, and the commits happen in that order.
- R8: Each lane computes `y = sat16(floor((x + offset) * gain / 32768))`, where x and offset are signed, gain is unsigned, and the result is clamped to the range -32768 to 32767.
- R9: The result of a sample presented with `s_valid` appears two clock edges later, and `m_valid` is `s_valid` delayed by two cycles.
- R10: `rd_req` is a single-cycle pulse, and no new request is issued before the previous one has been answered with `rd_valid`. A `rd_valid` that arrives while no request is outstanding changes no coefficient.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| range_sel | input | 2 | Selected input range code |
| rd_req | output | 1 | Byte read request pulse to the calibration store |
| rd_addr | output | 8 | Byte address of the request |
| rd_data | input | 8 | Returned byte |
| rd_valid | input | 1 | Response strobe for `rd_data` |
| busy | output | 1 | A coefficient load is in progress |
| s_valid | input | 1 | Input sample valid |
| s_data | input | 64 | Four signed 16-bit input lanes |
| m_valid | output | 1 | Corrected sample valid |
| m_data | output | 64 | Four corrected signed 16-bit lanes |

## Verification
The correction is driven with three kinds of sample input:
- An edge-value pattern of full-scale positive and negative values, zero and ±1. It separates wrong rounding and sign handling from correct ones.
- A 256-step sweep of the full input span on every lane. With record bytes that yield arbitrary gains, it catches overflow of the sum or the product.
- A gapped-valid stream. It distinguishes a correct valid delay from one that is off by a cycle.

Samples keep streaming across each load, so the exact commit edge is visible in the data. It shows a piecemeal coefficient update, and it shows any lane or byte swap in the record decoding. A dedicated record with unity, maximum and zero gains, combined with extreme offsets, forces both saturation limits.

// File: rtl/adc_cal_pkg.sv
package adc_cal_pkg;

    localparam int CAL_W = 16;
    localparam logic [CAL_W-1:0] CAL_UNITY = 16'h8000;

    typedef enum logic [1:0] {
        LD_IDLE = 2'd0,
        LD_REQ  = 2'd1,
        LD_WAIT = 2'd2
    } ld_state_e;

endpackage

// File: rtl/adc_cal_loader.sv
module adc_cal_loader
    import adc_cal_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int NRANGE = 3,
    parameter int AW     = 8,
    parameter int RW     = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [RW-1:0]             range_sel,
    output logic                      rd_req,
    output logic [AW-1:0]             rd_addr,
    input  logic [7:0]                rd_data,
    input  logic                      rd_valid,
    output logic                      busy,
    output logic [NCH-1:0][CAL_W-1:0] off_o,
    output logic [NCH-1:0][CAL_W-1:0] gain_o
);

    localparam int NWORDS     = 2 * NCH;
    localparam int LOAD_BYTES = 2 * NWORDS;
    localparam int REC_BYTES  = LOAD_BYTES + 2;
    localparam int BIDX_W     = $clog2(LOAD_BYTES);
    localparam logic [BIDX_W-1:0] LAST_BYTE = BIDX_W'(LOAD_BYTES - 1);

    typedef struct packed {
        ld_state_e                    st;
        logic [RW-1:0]                tgt;
        logic                         tgt_ok;
        logic                         pend;
        logic [RW-1:0]                pend_rng;
        logic [BIDX_W-1:0]            bidx;
        logic [NWORDS-1:0][CAL_W-1:0] stage;
        logic [NCH-1:0][CAL_W-1:0]    off;
        logic [NCH-1:0][CAL_W-1:0]    gain;
    } ld_regs_t;

    ld_regs_t q, d;

    logic              sel_ok;
    logic              start;
    logic [RW-1:0]     start_rng;
    logic [BIDX_W-2:0] widx;

    assign sel_ok = int'(range_sel) < NRANGE;
    assign widx   = q.bidx[BIDX_W-1:1];

    always_comb begin
        d         = q;
        start     = 1'b0;
        start_rng = q.tgt;
        case (q.st)
            LD_IDLE: begin
                if (q.pend) begin
                    start     = 1'b1;
                    start_rng = q.pend_rng;
                    d.pend    = 1'b0;
                end else if (sel_ok && (!q.tgt_ok || range_sel != q.tgt)) begin
                    start     = 1'b1;
                    start_rng = range_sel;
                end
            end
            LD_REQ: begin
                d.st = LD_WAIT;
            end
            LD_WAIT: begin
                if (rd_valid) begin
                    if (q.bidx[0]) d.stage[widx][15:8] = rd_data;
                    else           d.stage[widx][7:0]  = rd_data;
                    if (q.bidx == LAST_BYTE) begin
                        for (int c = 0; c < NCH; c++) begin
                            d.off[c]  = d.stage[c];
                            d.gain[c] = d.stage[NCH + c];
                        end
                        d.st = LD_IDLE;
                    end else begin
                        d.bidx = q.bidx + 1'b1;
                        d.st   = LD_REQ;
                    end
                end
            end
            default: d.st = LD_IDLE;
        endcase
        // a legal change seen while loading is held for the next load
        if (q.st != LD_IDLE && sel_ok && range_sel != q.tgt) begin
            d.pend     = 1'b1;
            d.pend_rng = range_sel;
        end
        if (start) begin
            d.tgt    = start_rng;
            d.tgt_ok = 1'b1;
            d.bidx   = '0;
            d.st     = LD_REQ;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
            for (int c = 0; c < NCH; c++) q.gain[c] <= CAL_UNITY;
        end else begin
            q <= d;
        end
    end

    assign rd_req  = (q.st == LD_REQ);
    assign rd_addr = AW'(int'(q.tgt) * REC_BYTES + int'(q.bidx));
    assign busy    = (q.st != LD_IDLE);
    assign off_o   = q.off;
    assign gain_o  = q.gain;

    p_req_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> !rd_req);

    p_addr_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> (int'(rd_addr) < NRANGE * REC_BYTES) &&
                   ((int'(rd_addr) % REC_BYTES) < LOAD_BYTES));

    p_coef_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> ($stable(off_o) && $stable(gain_o)));

    p_commit_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == LD_WAIT && rd_valid && q.bidx == LAST_BYTE) |=> !busy);

    p_idle_rsp_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == LD_IDLE && rd_valid) |=> $stable(q.stage));

endmodule

// File: rtl/adc_cal_chan.sv
module adc_cal_chan
    import adc_cal_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [CAL_W-1:0] x,
    input  logic [CAL_W-1:0] off,
    input  logic [CAL_W-1:0] gain,
    output logic             out_valid,
    output logic [CAL_W-1:0] y
);

    typedef struct packed {
        logic             v1;
        logic [CAL_W:0]   sum;
        logic [CAL_W-1:0] g1;
        logic             v2;
        logic [CAL_W-1:0] y;
    } ch_regs_t;

    ch_regs_t q, d;

    logic signed [2*CAL_W+1:0] prod;
    logic signed [2*CAL_W+1:0] shr;

    always_comb begin
        d     = q;
        // stage 1: widen and add offset; capture the gain beside it
        d.v1  = in_valid;
        d.sum = {x[CAL_W-1], x} + {off[CAL_W-1], off};
        d.g1  = gain;
        // stage 2: Q1.15 scale, floor shift, clamp
        prod  = $signed(q.sum) * $signed({1'b0, q.g1});
        shr   = prod >>> 15;
        d.v2  = q.v1;
        if (shr > 34'sd32767)       d.y = 16'h7FFF;
        else if (shr < -34'sd32768) d.y = 16'h8000;
        else                        d.y = shr[CAL_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign out_valid = q.v2;
    assign y         = q.y;

    p_lat_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ##1 out_valid);

    p_bubble_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ##1 !out_valid);

    p_unity_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.v1 && q.g1 == CAL_UNITY &&
         $signed(q.sum) <= 17'sd32767 && $signed(q.sum) >= -17'sd32768)
        |=> (y == $past(q.sum[CAL_W-1:0])));

endmodule

// File: rtl/adc_cal_corrector.sv
module adc_cal_corrector
    import adc_cal_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int NRANGE = 3,
    parameter int AW     = 8,
    parameter int RW     = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [RW-1:0]        range_sel,
    output logic                 rd_req,
    output logic [AW-1:0]        rd_addr,
    input  logic [7:0]           rd_data,
    input  logic                 rd_valid,
    output logic                 busy,
    input  logic                 s_valid,
    input  logic [NCH*CAL_W-1:0] s_data,
    output logic                 m_valid,
    output logic [NCH*CAL_W-1:0] m_data
);

    logic [NCH-1:0][CAL_W-1:0] off_w;
    logic [NCH-1:0][CAL_W-1:0] gain_w;
    logic [NCH-1:0]            lane_valid;

    adc_cal_loader #(
        .NCH    (NCH),
        .NRANGE (NRANGE),
        .AW     (AW),
        .RW     (RW)
    ) u_loader (
        .clk       (clk),
        .rst_n     (rst_n),
        .range_sel (range_sel),
        .rd_req    (rd_req),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid),
        .busy      (busy),
        .off_o     (off_w),
        .gain_o    (gain_w)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_lane
        adc_cal_chan u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .in_valid  (s_valid),
            .x         (s_data[c*CAL_W +: CAL_W]),
            .off       (off_w[c]),
            .gain      (gain_w[c]),
            .out_valid (lane_valid[c]),
            .y         (m_data[c*CAL_W +: CAL_W])
        );
    end

    assign m_valid = &lane_valid;

    p_lanes_agree_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_valid == '0) || (&lane_valid));

endmodule

// File: tb/adc_cal_corrector_bench.sv
`timescale 1ns/1ps
module adc_cal_corrector_bench;

    localparam int NCH = 4;
    localparam int REC = 18;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  range_sel;
    logic        rd_req;
    logic [7:0]  rd_addr;
    logic [7:0]  rd_data;
    logic        rd_valid;
    logic        busy;
    logic        s_valid;
    logic [63:0] s_data;
    logic        m_valid;
    logic [63:0] m_data;

    always #2 clk = ~clk;

    adc_cal_corrector u_adc_cal_corrector (
        .clk(clk), .rst_n(rst_n), .range_sel(range_sel),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid),
        .busy(busy), .s_valid(s_valid), .s_data(s_data),
        .m_valid(m_valid), .m_data(m_data)
    );

    logic [7:0] mem [0:3*REC-1];
    int checks = 0;
    int errors = 0;
    int cur_off  [NCH];
    int cur_gain [NCH];
    int load_q[$];
    int load_list[$];
    int req_idx = 0;
    int lat_cnt = 0;
    int inj_cnt = 0;
    int inj_done = 0;
    logic [7:0] pend_addr;
    bit v1 = 0, v2 = 0;
    int e1 [NCH];
    int e2 [NCH];

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int corr(input int x, input int off, input int g);
        longint s, p, r;
        s = longint'(x) + longint'(off);
        p = s * longint'(g);
        r = p >>> 15;
        if (r > 32767)  r = 32767;
        if (r < -32768) r = -32768;
        return int'(r);
    endfunction

    function automatic int gen(input int mode, input int i, input int c);
        int edges [8] = '{-32768, -32767, -1, 0, 1, 32767, 16384, -16384};
        case (mode)
            0:       return edges[(i + 3*c) % 8];
            1:       return ((i*257 + c*4099) % 65536) - 32768;
            2:       return ((i*613 + c*12345 + 77) % 65536) - 32768;
            default: return 0;
        endcase
    endfunction

    // calibration store model, R2 address order checked on each request
    always @(negedge clk) begin
        rd_valid = 1'b0;
        if (lat_cnt > 0) begin
            lat_cnt--;
            if (lat_cnt == 0) begin
                rd_valid = 1'b1;
                rd_data  = mem[int'(pend_addr)];
            end
        end else if (inj_done != inj_cnt) begin
            rd_valid = 1'b1;
            rd_data  = 8'hFF;
            inj_done++;
        end
        if (rd_req === 1'b1) begin
            int exp_a;
            exp_a = (req_idx / 16 < load_list.size()) ?
                    REC * load_list[req_idx / 16] + (req_idx % 16) : -1;
            chk(int'(rd_addr) == exp_a, "R2 request address", rd_addr, exp_a);
            chk(lat_cnt == 0, "R10 request while outstanding", lat_cnt, 0);
            pend_addr = rd_addr;
            lat_cnt   = 3;
            req_idx++;
        end
    end

    // bench-side coefficient model: switch at the commit edge (R3 R4 R5 R7)
    always @(negedge busy) begin
        if (rst_n === 1'b1 && load_q.size() > 0) begin
            int r;
            r = load_q.pop_front();
            for (int c = 0; c < NCH; c++) begin
                cur_off[c]  = int'($signed({mem[REC*r + 2*c + 1], mem[REC*r + 2*c]}));
                cur_gain[c] = int'({mem[REC*r + 8 + 2*c + 1], mem[REC*r + 8 + 2*c]});
            end
        end
    end

    task automatic run(input int n, input int mode);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(m_valid == v2, "R9 m_valid delay", m_valid, v2);
            if (v2) begin
                for (int c = 0; c < NCH; c++)
                    chk(int'($signed(m_data[c*16 +: 16])) == e2[c], "R8 lane result",
                        int'($signed(m_data[c*16 +: 16])), e2[c]);
            end
            v2 = v1;
            e2 = e1;
            v1 = (mode == 3) ? 1'b0 : (mode == 2) ? (i % 3 != 0) : 1'b1;
            for (int c = 0; c < NCH; c++) begin
                int x;
                x = gen(mode, i, c);
                s_data[c*16 +: 16] = 16'(x);
                e1[c] = corr(x, cur_off[c], cur_gain[c]);
            end
            s_valid = v1;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R9 watchdog actual %0d expected %0d", 150000, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 3*REC; i++) mem[i] = 8'((i*73 + 29) ^ (i >> 1));
        for (int c = 0; c < NCH; c++) begin
            cur_off[c] = 0; cur_gain[c] = 32768; e1[c] = 0; e2[c] = 0;
        end
        rst_n = 1'b0; range_sel = 2'd0; rd_valid = 1'b0; rd_data = 8'h00;
        s_valid = 1'b0; s_data = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(busy == 1'b0, "R1 busy in reset", busy, 0);
        chk(rd_req == 1'b0, "R1 rd_req in reset", rd_req, 0);
        chk(m_valid == 1'b0, "R1 m_valid in reset", m_valid, 0);
        load_list.push_back(0); load_q.push_back(0);
        rst_n = 1'b1;
        // R1 unity pass-through while the first load runs, then R5 switch
        run(60, 0);
        chk(busy == 1'b1, "R5 busy during load", busy, 1);
        run(80, 1);
        chk(busy == 1'b0, "R5 busy after load", busy, 0);
        chk(req_idx == 16, "R2 reads per load", req_idx, 16);
        run(256, 1);
        run(100, 2);
        // range 2 (100 mV)
        load_list.push_back(2); load_q.push_back(2);
        range_sel = 2'd2;
        run(200, 2);
        chk(req_idx == 32, "R2 reads after range 2", req_idx, 32);
        // R6: illegal code and reselecting the loaded range
        range_sel = 2'd3;
        run(30, 0);
        range_sel = 2'd2;
        run(30, 0);
        chk(req_idx == 32, "R6 no reads for code 3 or same range", req_idx, 32);
        chk(busy == 1'b0, "R6 busy stays low", busy, 0);
        // R7: change during a load is latched
        load_list.push_back(1); load_q.push_back(1);
        load_list.push_back(0); load_q.push_back(0);
        range_sel = 2'd1;
        run(10, 1);
        range_sel = 2'd0;
        run(300, 1);
        chk(req_idx == 64, "R7 two loads in order", req_idx, 64);
        chk(load_q.size() == 0, "R7 both commits seen", load_q.size(), 0);
        // R10: stray response while idle changes nothing
        inj_cnt++;
        run(10, 3);
        run(40, 0);
        chk(req_idx == 64, "R10 stray response starts no reads", req_idx, 64);
        // R8 saturation record for range 1
        begin
            int offs [NCH] = '{0, 32767, -32768, 100};
            int gns  [NCH] = '{32768, 65535, 65535, 0};
            for (int c = 0; c < NCH; c++) begin
                mem[REC + 2*c]         = 8'(offs[c]);
                mem[REC + 2*c + 1]     = 8'(offs[c] >> 8);
                mem[REC + 8 + 2*c]     = 8'(gns[c]);
                mem[REC + 8 + 2*c + 1] = 8'(gns[c] >> 8);
            end
        end
        load_list.push_back(1); load_q.push_back(1);
        range_sel = 2'd1;
        run(120, 3);
        chk(busy == 1'b0, "R5 saturation record committed", busy, 0);
        run(40, 0);
        run(256, 1);
        run(4, 3);
        chk(req_idx == 80, "R2 reads total", req_idx, 80);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule